// File: doc/BRIEF.md
# 8-bit ALU with registered flag byte

This block is the arithmetic and logic unit of a small 8-bit processor core. Each cycle it takes an operation code, a destination operand and a source operand, and it produces a result and a proposed new flag byte, all combinationally. The operations are addition and subtraction with and without carry, compare, the three bitwise logical operations, four single-bit rotates, decimal adjust and complement. The flag byte lives in a register inside the block. Its present value feeds carry, subtract and half-carry back into the operations that need them.

The sequencer around the block routes operands in and takes the result out. It pulses an enable strobe in the cycle that should commit the new flags. Without the strobe the combinational outputs still follow the inputs, but the stored flags do not move. Operand fetch and 16-bit register-pair arithmetic belong to the sequencer.

Top module: `alu8_core`

## Requirements
- R1: The flag byte is laid out as bit 0 carry (C), bit 1 subtract (N), bit 2 parity (P), bit 4 half carry (AC), bit 6 zero (Z) and bit 7 sign (S). Bits 3 and 5 always read 0. Reset clears the stored flags to 0x00. Where an operation computes P, Z and S, P is 1 for an even count of ones in the 8-bit value, Z is 1 for a zero value, and S copies bit 7.
- R2: The 4-bit operation codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare, 8 rotate left, 9 rotate right, 10 rotate left through carry, 11 rotate right through carry, 12 decimal adjust, 13 complement. Codes 14 and 15 pass the destination through.
- R3: Add (code 0) and add-with-carry (code 1, which adds the stored C) give dst+src(+C) modulo 256. The carry out of bit 7 goes to C, the carry out of bit 3 (incoming carry included) goes to AC, and N is cleared. P, Z and S come from the result.
- R4: Subtract (code 2) and subtract-with-borrow (code 3, which also subtracts the stored C) give dst-src(-C) modulo 256. C is set on a borrow out of bit 7, AC on a borrow out of the low nibble (incoming borrow included), and N is set. P, Z and S come from the result.
- R5: Compare (code 7) updates all flags exactly as subtract does, but outputs the destination unchanged.
- R6: AND gives C=0, AC=1 and N=0. XOR and OR give C=0, AC=0 and N=0. P, Z and S come from the logical result.
- R7: Code 8 rotates the 8 bits left and copies the old bit 7 into C. Code 9 rotates right and copies the old bit 0 into C. No other flag changes.
- R8: Code 10 rotates left through carry as a 9-bit ring: the old C enters bit 0 and the old bit 7 goes to C. Code 11 does the same to the right: the old C enters bit 7 and the old bit 0 goes to C. No other flag changes.
- R9: Decimal adjust (code 12) outputs dst+6 when AC=1 and N=0, dst-6 when AC=1 and N=1, and dst unchanged when AC=0. All flags are left as they were.
- R10: Complement (code 13) outputs the bitwise inverse of the destination. It and codes 14 and 15 leave all flags as they were.
- R11: The stored flag byte takes the proposed flag byte at a rising clock edge where the enable is high, and holds its value at every other edge. The proposed flag byte is a combinational output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| alu_en | input | 1 | Commit strobe for the flag register |
| alu_op | input | 4 | Operation code |
| opd_dst | input | 8 | Destination operand |
| opd_src | input | 8 | Source operand |
| alu_result | output | 8 | Combinational result |
| flags_next | output | 8 | Proposed flag byte for the current operation |
| flags_q | output | 8 | Stored flag byte |

## Verification
The directed part covers the edges of the arithmetic: wraparound to zero, a borrow from zero, nibble carries that depend only on the incoming carry, and a compare where the destination is smaller. Together these separate carry from half carry and show whether the carry-in is honoured. Decimal adjust runs three times: after an addition, after a subtraction and with AC clear. This shows that it reads N and AC from the stored flags and not from the current operands. Rotates run with C both set and clear, which separates the plain rotates from the through-carry rotates. A long random run follows in which the strobe is often low. That run catches flags that commit without the strobe or that lose bits another operation left behind.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int FLAG_W = 8;
   localparam int NIB_W  = 4;

   // Flag byte bit positions; other stages decode these fields.
   localparam int FB_C  = 0;
   localparam int FB_N  = 1;
   localparam int FB_P  = 2;
   localparam int FB_AC = 4;
   localparam int FB_Z  = 6;
   localparam int FB_S  = 7;

   typedef logic [FLAG_W-1:0] flag_t;

   typedef enum logic [3:0] {
      OP_ADD    = 4'd0,
      OP_ADDC   = 4'd1,
      OP_SUB    = 4'd2,
      OP_SUBB   = 4'd3,
      OP_AND    = 4'd4,
      OP_XOR    = 4'd5,
      OP_OR     = 4'd6,
      OP_CMP    = 4'd7,
      OP_ROL    = 4'd8,
      OP_ROR    = 4'd9,
      OP_ROLT   = 4'd10,
      OP_RORT   = 4'd11,
      OP_DECADJ = 4'd12,
      OP_INV    = 4'd13,
      OP_PASS14 = 4'd14,
      OP_PASS15 = 4'd15
   } alu_op_e;

   // Assemble a flag byte; the unused bits stay zero.
   function automatic flag_t pack_flags(input logic s, input logic z, input logic ac,
                                        input logic p, input logic n, input logic c);
      flag_t f;
      f        = '0;
      f[FB_S]  = s;
      f[FB_Z]  = z;
      f[FB_AC] = ac;
      f[FB_P]  = p;
      f[FB_N]  = n;
      f[FB_C]  = c;
      return f;
   endfunction

endpackage

// File: rtl/alu8_addsub.sv
// Shared adder/subtractor: one wide path for the carry out, one nibble path
// for the half carry.
module alu8_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         carry_in,
   input  logic         use_carry,
   input  logic         is_sub,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         half
);
   localparam int NW = alu8_pkg::NIB_W;

   logic          cin;
   logic [W:0]    wide;
   logic [NW:0]   nib;

   assign cin = use_carry & carry_in;

   always_comb begin
      if (is_sub) begin
         wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
         nib  = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
      end else begin
         wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
         nib  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
      end
   end

   // Top bit of each extended path is the carry (add) or borrow (subtract).
   assign sum  = wide[W-1:0];
   assign cout = wide[W];
   assign half = nib[NW];

endmodule

// File: rtl/alu8_logic.sv
// Bitwise unit; the low two op bits select AND (00), XOR (01), OR (10).
module alu8_logic #(
   parameter int W = 8
) (
   input  logic [1:0]   sel,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   always_comb begin
      unique case (sel)
         2'b00:   y = a & b;
         2'b01:   y = a ^ b;
         2'b10:   y = a | b;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/alu8_parity.sv
// Even-parity detector; FOLD selects a reduction operator or an explicit
// bit-serial fold (same function, different netlist shape).
module alu8_parity #(
   parameter int W    = 8,
   parameter bit FOLD = 1'b0
) (
   input  logic [W-1:0] v,
   output logic         even
);
   generate
      if (FOLD) begin : g_fold
         always_comb begin
            logic acc;
            acc = 1'b1;
            for (int i = 0; i < W; i++) begin
               acc = acc ^ v[i];
            end
            even = acc;
         end
      end else begin : g_reduce
         assign even = ~(^v);
      end
   endgenerate
endmodule

// File: rtl/alu8_shift.sv
// Rotates, decimal adjust, complement and pass-through for op codes 8..15.
module alu8_shift #(
   parameter int W      = 8,
   parameter int ADJ_K  = 6
) (
   input  alu8_pkg::alu_op_e op,
   input  logic [W-1:0]      a,
   input  logic              c_in,
   input  logic              n_in,
   input  logic              ac_in,
   output logic [W-1:0]      y,
   output logic              c_out
);
   import alu8_pkg::*;

   localparam logic [W-1:0] ADJ = W'(ADJ_K);

   always_comb begin
      y     = a;
      c_out = c_in;
      unique case (op)
         OP_ROL: begin
            y     = {a[W-2:0], a[W-1]};
            c_out = a[W-1];
         end
         OP_ROR: begin
            y     = {a[0], a[W-1:1]};
            c_out = a[0];
         end
         OP_ROLT: begin
            y     = {a[W-2:0], c_in};
            c_out = a[W-1];
         end
         OP_RORT: begin
            y     = {c_in, a[W-1:1]};
            c_out = a[0];
         end
         OP_DECADJ: begin
            if (ac_in) y = n_in ? (a - ADJ) : (a + ADJ);
         end
         OP_INV: y = ~a;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/alu8_core.sv
// ALU top: operand units, flag assembly and the committed flag register.
module alu8_core #(
   parameter int W          = 8,
   parameter bit PAR_FOLD   = 1'b0,
   parameter int ADJ_K      = 6,
   parameter logic [7:0] FLAG_RST = 8'h00
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         alu_en,
   input  logic [3:0]   alu_op,
   input  logic [W-1:0] opd_dst,
   input  logic [W-1:0] opd_src,
   output logic [W-1:0] alu_result,
   output logic [7:0]   flags_next,
   output logic [7:0]   flags_q
);
   import alu8_pkg::*;

   localparam int NW = NIB_W;

   generate
      if (W < 2 * NW) begin : g_bad_w
         $error("alu8_core: W must be at least two nibbles");
      end
      if (FLAG_RST[3] || FLAG_RST[5]) begin : g_bad_rst
         $error("alu8_core: reserved flag bits must reset to zero");
      end
      if (ADJ_K >= (1 << NW)) begin : g_bad_adj
         $error("alu8_core: decimal adjust constant must fit a nibble");
      end
   endgenerate

   alu_op_e      op_e;
   logic         is_sub;
   logic         use_carry;
   logic         is_logic;
   logic [W-1:0] arith_y;
   logic         arith_c;
   logic         arith_h;
   logic [W-1:0] logic_y;
   logic [W-1:0] shift_y;
   logic         shift_c;
   logic [W-1:0] flag_src;
   logic         src_even;
   logic         src_zero;
   flag_t        nxt;
   flag_t        fq;

   assign op_e      = alu_op_e'(alu_op);
   assign is_sub    = (op_e == OP_SUB) || (op_e == OP_SUBB) || (op_e == OP_CMP);
   assign use_carry = (op_e == OP_ADDC) || (op_e == OP_SUBB);
   assign is_logic  = (op_e == OP_AND) || (op_e == OP_XOR) || (op_e == OP_OR);

   alu8_addsub #(.W(W)) u_addsub (
      .a         (opd_dst),
      .b         (opd_src),
      .carry_in  (fq[FB_C]),
      .use_carry (use_carry),
      .is_sub    (is_sub),
      .sum       (arith_y),
      .cout      (arith_c),
      .half      (arith_h)
   );

   alu8_logic #(.W(W)) u_logic (
      .sel (alu_op[1:0]),
      .a   (opd_dst),
      .b   (opd_src),
      .y   (logic_y)
   );

   alu8_shift #(.W(W), .ADJ_K(ADJ_K)) u_shift (
      .op    (op_e),
      .a     (opd_dst),
      .c_in  (fq[FB_C]),
      .n_in  (fq[FB_N]),
      .ac_in (fq[FB_AC]),
      .y     (shift_y),
      .c_out (shift_c)
   );

   // One parity/zero detector serves both the arithmetic and logical paths.
   assign flag_src = is_logic ? logic_y : arith_y;
   assign src_zero = (flag_src == '0);

   alu8_parity #(.W(W), .FOLD(PAR_FOLD)) u_par (
      .v    (flag_src),
      .even (src_even)
   );

   always_comb begin
      alu_result = shift_y;
      nxt        = fq;
      unique case (op_e)
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
            alu_result = arith_y;
            nxt = pack_flags(arith_y[W-1], src_zero, arith_h, src_even, is_sub, arith_c);
         end
         OP_CMP: begin
            alu_result = opd_dst;
            nxt = pack_flags(arith_y[W-1], src_zero, arith_h, src_even, 1'b1, arith_c);
         end
         OP_AND: begin
            alu_result = logic_y;
            nxt = pack_flags(logic_y[W-1], src_zero, 1'b1, src_even, 1'b0, 1'b0);
         end
         OP_XOR, OP_OR: begin
            alu_result = logic_y;
            nxt = pack_flags(logic_y[W-1], src_zero, 1'b0, src_even, 1'b0, 1'b0);
         end
         OP_ROL, OP_ROR, OP_ROLT, OP_RORT: begin
            nxt[FB_C] = shift_c;
         end
         default: begin
            nxt = fq;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fq <= FLAG_RST;
      end else if (alu_en) begin
         fq <= nxt;
      end
   end

   assign flags_next = nxt;
   assign flags_q    = fq;

endmodule

// File: rtl/alu8_core_chk.sv
// Property checker bound to the ALU top.
module alu8_core_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         alu_en,
   input logic [3:0]   alu_op,
   input logic [W-1:0] opd_dst,
   input logic [W-1:0] opd_src,
   input logic [W-1:0] alu_result,
   input logic [7:0]   flags_next,
   input logic [7:0]   flags_q
);

   p_fixed_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[3] == 1'b0) && (flags_q[5] == 1'b0));

   p_add_n_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_en && (alu_op == 4'd0 || alu_op == 4'd1)) |=> !flags_q[1]);

   p_sub_n_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_en && (alu_op == 4'd2 || alu_op == 4'd3)) |=> flags_q[1]);

   p_cmp_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op == 4'd7) |-> (alu_result == opd_dst));

   p_and_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_en && alu_op == 4'd4) |=> (flags_q[4] && !flags_q[0]));

   p_and_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_en && alu_op == 4'd4) |=> (flags_q[6] == ($past(alu_result) == '0)));

   p_rol_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_en && alu_op == 4'd8) |=> (flags_q[0] == $past(opd_dst[W-1])));

   p_ring_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op == 4'd10) |-> (alu_result[0] == flags_q[0]));

   p_adj_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op == 4'd12) |-> (flags_next == flags_q));

   p_inv_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op == 4'd13) |-> ((alu_result == ~opd_dst) && (flags_next == flags_q)));

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !alu_en |=> $stable(flags_q));

endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .alu_en     (alu_en),
   .alu_op     (alu_op),
   .opd_dst    (opd_dst),
   .opd_src    (opd_src),
   .alu_result (alu_result),
   .flags_next (flags_next),
   .flags_q    (flags_q)
);

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;

   localparam real CLK_HALF = 10.0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       alu_en = 1'b0;
   logic [3:0] alu_op = 4'd0;
   logic [7:0] opd_dst = 8'h00;
   logic [7:0] opd_src = 8'h00;
   logic [7:0] alu_result;
   logic [7:0] flags_next;
   logic [7:0] flags_q;

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] mflags = 8'h00;
   bit done = 1'b0;

   always #(CLK_HALF) clk = ~clk;

   alu8_core uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .alu_en     (alu_en),
      .alu_op     (alu_op),
      .opd_dst    (opd_dst),
      .opd_src    (opd_src),
      .alu_result (alu_result),
      .flags_next (flags_next),
      .flags_q    (flags_q)
   );

   // Flag byte from R1: {S, Z, 0, AC, 0, P, N, C}
   function automatic logic [7:0] mkf(input logic [7:0] r, input bit ac, input bit n, input bit c);
      bit even;
      even = ($countones(r) % 2) == 0;
      return {r[7], (r == 8'h00), 1'b0, ac, 1'b0, even, n, c};
   endfunction

   function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] d,
                                         input logic [7:0] s, input logic [7:0] f);
      logic [7:0] r;
      logic [7:0] nf;
      int ci;
      r  = d;
      nf = f;
      ci = int'(f[0]);
      case (op)
         4'd0, 4'd1: begin
            if (op == 4'd0) ci = 0;
            r  = 8'(int'(d) + int'(s) + ci);
            nf = mkf(r, (int'(d[3:0]) + int'(s[3:0]) + ci) > 15, 1'b0,
                     (int'(d) + int'(s) + ci) > 255);
         end
         4'd2, 4'd3, 4'd7: begin
            if (op != 4'd3) ci = 0;
            r  = 8'(int'(d) - int'(s) - ci);
            nf = mkf(r, int'(d[3:0]) < int'(s[3:0]) + ci, 1'b1, int'(d) < int'(s) + ci);
            if (op == 4'd7) r = d;
         end
         4'd4: begin r = d & s; nf = mkf(r, 1'b1, 1'b0, 1'b0); end
         4'd5: begin r = d ^ s; nf = mkf(r, 1'b0, 1'b0, 1'b0); end
         4'd6: begin r = d | s; nf = mkf(r, 1'b0, 1'b0, 1'b0); end
         4'd8:  begin r = {d[6:0], d[7]}; nf[0] = d[7]; end
         4'd9:  begin r = {d[0], d[7:1]}; nf[0] = d[0]; end
         4'd10: begin r = {d[6:0], f[0]}; nf[0] = d[7]; end
         4'd11: begin r = {f[0], d[7:1]}; nf[0] = d[0]; end
         4'd12: begin
            if (f[4]) r = f[1] ? 8'(int'(d) - 6) : 8'(int'(d) + 6);
         end
         4'd13: r = ~d;
         default: r = d;
      endcase
      return {r, nf};
   endfunction

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd1:        return "R3";
         4'd2, 4'd3:        return "R4";
         4'd7:              return "R5";
         4'd4, 4'd5, 4'd6:  return "R6";
         4'd8, 4'd9:        return "R7";
         4'd10, 4'd11:      return "R8";
         4'd12:             return "R9";
         default:           return "R10";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_op(input logic [3:0] op, input logic [7:0] d, input logic [7:0] s, input bit en);
      logic [15:0] e;
      @(negedge clk);
      chk("R11", "stored flags", flags_q, mflags);
      alu_op  = op;
      opd_dst = d;
      opd_src = s;
      alu_en  = en;
      #1;
      e = model(op, d, s, mflags);
      chk({req_of(op), " R2"}, $sformatf("result op=%0d", op), alu_result, e[15:8]);
      chk({req_of(op), " R2"}, $sformatf("next flags op=%0d", op), flags_next, e[7:0]);
      chk("R1", "reserved flag bits", {6'd0, flags_next[5], flags_next[3]}, 8'h00);
      @(posedge clk);
      if (en) mflags = e[7:0];
   endtask

   initial begin
      #(CLK_HALF * 2 * 100000);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24680));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "reset flags", flags_q, 8'h00);
      rst_n = 1'b1;

      // R3: wrap to zero sets C, AC, Z, P
      do_op(4'd0, 8'hFF, 8'h01, 1'b1);
      // R3: carry-in alone makes the nibble carry
      do_op(4'd1, 8'h0F, 8'h00, 1'b1);
      do_op(4'd0, 8'h7F, 8'h01, 1'b1);
      // R4: borrow from zero
      do_op(4'd2, 8'h00, 8'h01, 1'b1);
      // R4: borrow-in feeds nibble borrow
      do_op(4'd3, 8'h10, 8'h00, 1'b1);
      // R5: compare smaller destination
      do_op(4'd7, 8'h05, 8'h07, 1'b1);
      do_op(4'd7, 8'h42, 8'h42, 1'b1);
      // R6
      do_op(4'd4, 8'hF0, 8'h0F, 1'b1);
      do_op(4'd5, 8'hA5, 8'h5A, 1'b1);
      do_op(4'd6, 8'h80, 8'h01, 1'b1);
      // R7 and R8 with C both set and clear
      do_op(4'd8, 8'h80, 8'h00, 1'b1);
      do_op(4'd10, 8'h01, 8'h00, 1'b1);
      do_op(4'd11, 8'h02, 8'h00, 1'b1);
      do_op(4'd9, 8'h01, 8'h00, 1'b1);
      do_op(4'd11, 8'h00, 8'h00, 1'b1);
      // R9: adjust after an addition with AC, after a subtraction with AC, without AC
      do_op(4'd0, 8'h09, 8'h08, 1'b1);
      do_op(4'd12, 8'h11, 8'h00, 1'b1);
      do_op(4'd2, 8'h10, 8'h01, 1'b1);
      do_op(4'd12, 8'h0F, 8'h00, 1'b1);
      do_op(4'd6, 8'h00, 8'h00, 1'b1);
      do_op(4'd12, 8'h33, 8'h00, 1'b1);
      // R10
      do_op(4'd13, 8'h3C, 8'h00, 1'b1);
      do_op(4'd14, 8'h99, 8'h11, 1'b1);
      do_op(4'd15, 8'h00, 8'hFF, 1'b1);
      // R11: no commit without the strobe
      do_op(4'd0, 8'hFF, 8'hFF, 1'b0);
      do_op(4'd2, 8'h00, 8'h80, 1'b0);

      for (int i = 0; i < 600; i++) begin
         logic [3:0] op;
         logic [7:0] d;
         logic [7:0] s;
         bit en;
         op = 4'($urandom_range(0, 15));
         d  = 8'($urandom);
         s  = 8'($urandom);
         if ((i % 5) == 0) d = 8'($urandom_range(0, 2)) * 8'h7F;
         en = ($urandom_range(0, 3) != 0);
         do_op(op, d, s, en);
      end

      @(negedge clk);
      chk("R11", "stored flags at end", flags_q, mflags);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule